// File: doc/BRIEF.md
# Single Load/Store Address Generator

This block forms the memory address and the updated base value for a load or store that moves one register. Each request supplies a base value and an offset. The offset is either an immediate or an index register. For word and unsigned-byte accesses the index register may be shifted first. The offset is added to or subtracted from the base. Pre/post-index and writeback controls then decide which value goes to memory and whether the base register is rewritten.

Results are registered, so they appear one clock after the request. The writeback enable is held low when the request's condition has failed. The same cycle, the block formats the raw memory word returned for a load. It selects the byte or halfword lane from the low bits of the registered address (little-endian) and zero- or sign-extends it according to the access size.

Top module: `ls_agen`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it, `outValid` and `wbEnable` are 0.
- R2: For size codes word (0) and unsigned byte (1), an immediate offset (`offIsReg`=0) uses all 12 bits of `immOff` (0 to 4095), zero-extended.
- R3: For size codes 0 and 1, a register offset (`offIsReg`=1) is `indexReg` shifted by `shiftAmt` places. `shiftKind` selects the shift: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. A `shiftAmt` of 0 leaves the register unshifted.
- R4: For size codes unsigned halfword (2), signed byte (3) and signed halfword (4), an immediate offset uses only `immOff[7:0]`, and `immOff[11:8]` is ignored. A register offset is `indexReg` unshifted, and `shiftKind`/`shiftAmt` are ignored.
- R5: With `addOffset`=1 the offset is added to the base, and with 0 it is subtracted. With `preIndex`=1, `effAddr` is base±offset. With `preIndex`=0, `effAddr` is the unmodified base.
- R6: `wbValue` is always base±offset. `wbEnable` is 1 for a valid request with a passing condition that is post-indexed, or pre-indexed with `writeBack`=1.
- R7: When `condPass`=0, `wbEnable` is 0. The address outputs are still produced.
- R8: `loadData` formats `rdWord` from the registered `effAddr` and size, as follows:
  - word: passed through unchanged;
  - unsigned byte: the byte at lane `effAddr[1:0]`, zero-extended;
  - unsigned halfword: the halfword at lane `effAddr[1]`, zero-extended;
  - signed byte: that byte, sign-extended from bit 7;
  - signed halfword: that halfword, sign-extended from bit 15.
- R9: `outValid`, `effAddr`, `wbValue` and `wbEnable` reflect the request presented at the previous rising clock edge. `outValid` equals the `reqValid` sampled there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| sizeClass | input | 3 | 0 word, 1 unsigned byte, 2 unsigned halfword, 3 signed byte, 4 signed halfword |
| base | input | 32 | Base register value |
| indexReg | input | 32 | Index register value |
| immOff | input | 12 | Immediate offset |
| offIsReg | input | 1 | 1 selects the index register as the offset |
| shiftKind | input | 2 | Index shift type |
| shiftAmt | input | 5 | Index shift distance |
| addOffset | input | 1 | 1 add, 0 subtract |
| preIndex | input | 1 | 1 pre-indexed, 0 post-indexed |
| writeBack | input | 1 | Writeback request for the pre-indexed form |
| condPass | input | 1 | Condition of the access passed |
| rdWord | input | 32 | Raw word returned by memory for the registered access |
| outValid | output | 1 | Registered results valid |
| effAddr | output | 32 | Address to access |
| wbValue | output | 32 | New base value |
| wbEnable | output | 1 | Write `wbValue` back to the base register |
| loadData | output | 32 | Extended load result |

## Verification
A wrong decode of the access size would show in the next cycle in two ways. The offset in `effAddr` would be too large, because the short immediate's upper nibble or the index shift was not masked off. The upper bits of `loadData` would also come out with the wrong extension. A wrong pre/post or condition decision would corrupt the base register at once: `wbEnable` would pulse, or fail to pulse, on the same registered cycle that `effAddr` shows the base or the sum. An error in lane selection would show in `loadData` as a neighbouring byte as soon as `outValid` rises.

// File: rtl/ls_agen_pkg.sv
package ls_agen_pkg;
  typedef enum logic [2:0] {
    SZ_WORD  = 3'd0,
    SZ_UBYTE = 3'd1,
    SZ_UHALF = 3'd2,
    SZ_SBYTE = 3'd3,
    SZ_SHALF = 3'd4
  } sizeClass_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // request accepted this cycle
    logic shortImm;  // restrict immediate to its low field
    logic shiftEn;   // allow index shift
    logic subtract;  // base minus offset
    logic usePre;    // address is the sum
    logic wbGate;    // base writeback permitted
  } agStrobe_t;
endpackage

// File: rtl/ls_agen_ctrl.sv
module ls_agen_ctrl
  import ls_agen_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] sizeClass,
  input  logic       addOffset,
  input  logic       preIndex,
  input  logic       writeBack,
  input  logic       condPass,
  output agStrobe_t  strobe
);
  sizeClass_e sz;
  logic wideForm;

  always_comb begin
    sz       = sizeClass_e'(sizeClass);
    wideForm = (sz == SZ_WORD) || (sz == SZ_UBYTE);
    strobe.capture  = reqValid;
    strobe.shortImm = !wideForm;
    strobe.shiftEn  = wideForm;
    strobe.subtract = !addOffset;
    strobe.usePre   = preIndex;
    strobe.wbGate   = reqValid && condPass && (!preIndex || writeBack);
  end
endmodule

// File: rtl/ls_agen_shift.sv
module ls_agen_shift #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] valIn,
  input  logic [1:0]        kind,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] valOut
);
  logic [2*DATA_W-1:0] rotPair;

  always_comb begin
    rotPair = {valIn, valIn} >> amt;
    if (amt == '0) begin
      valOut = valIn;
    end else begin
      unique case (kind)
        2'd0:    valOut = valIn << amt;
        2'd1:    valOut = valIn >> amt;
        2'd2:    valOut = DATA_W'($signed(valIn) >>> amt);
        default: valOut = rotPair[DATA_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/ls_agen_ldfmt.sv
module ls_agen_ldfmt
  import ls_agen_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANE_W = $clog2(DATA_W / 8)
) (
  input  logic [DATA_W-1:0] rdWord,
  input  logic [LANE_W-1:0] laneAddr,
  input  logic [2:0]        sizeClass,
  output logic [DATA_W-1:0] loadData
);
  logic [DATA_W-1:0] byteShifted, halfShifted;
  logic [7:0]  pickByte;
  logic [15:0] pickHalf;

  always_comb begin
    byteShifted = rdWord >> ({3'b000, laneAddr} * 8);
    halfShifted = rdWord >> ({3'b000, laneAddr[LANE_W-1:1], 1'b0} * 8);
    pickByte = byteShifted[7:0];
    pickHalf = halfShifted[15:0];
    unique case (sizeClass_e'(sizeClass))
      SZ_UBYTE: loadData = DATA_W'(pickByte);
      SZ_UHALF: loadData = DATA_W'(pickHalf);
      SZ_SBYTE: loadData = {{(DATA_W-8){pickByte[7]}}, pickByte};
      SZ_SHALF: loadData = {{(DATA_W-16){pickHalf[15]}}, pickHalf};
      default:  loadData = rdWord;
    endcase
  end
endmodule

// File: rtl/ls_agen_dp.sv
module ls_agen_dp
  import ls_agen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W = 12,
  parameter int SHORT_IMM_W = 8,
  localparam int AMT_W = $clog2(DATA_W),
  localparam int LANE_W = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  agStrobe_t         strobe,
  input  logic [2:0]        sizeClass,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] indexReg,
  input  logic [IMM_W-1:0]  immOff,
  input  logic              offIsReg,
  input  logic [1:0]        shiftKind,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic [DATA_W-1:0] rdWord,
  output logic              outValid,
  output logic [DATA_W-1:0] effAddr,
  output logic [DATA_W-1:0] wbValue,
  output logic              wbEnable,
  output logic [DATA_W-1:0] loadData
);
  logic [DATA_W-1:0] shiftedIdx, offset, sum;
  logic [2:0]        sizeQ;

  ls_agen_shift #(.DATA_W(DATA_W)) u_shift (
    .valIn (indexReg),
    .kind  (shiftKind),
    .amt   (shiftAmt),
    .valOut(shiftedIdx)
  );

  always_comb begin
    if (offIsReg)
      offset = strobe.shiftEn ? shiftedIdx : indexReg;
    else if (strobe.shortImm)
      offset = DATA_W'(immOff[SHORT_IMM_W-1:0]);
    else
      offset = DATA_W'(immOff);
    sum = strobe.subtract ? (base - offset) : (base + offset);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wbEnable <= 1'b0;
      effAddr  <= '0;
      wbValue  <= '0;
      sizeQ    <= '0;
    end else begin
      outValid <= strobe.capture;
      wbEnable <= strobe.wbGate;
      if (strobe.capture) begin
        effAddr <= strobe.usePre ? sum : base;
        wbValue <= sum;
        sizeQ   <= sizeClass;
      end
    end
  end

  ls_agen_ldfmt #(.DATA_W(DATA_W)) u_fmt (
    .rdWord   (rdWord),
    .laneAddr (effAddr[LANE_W-1:0]),
    .sizeClass(sizeQ),
    .loadData (loadData)
  );
endmodule

// File: rtl/ls_agen.sv
module ls_agen
  import ls_agen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W = 12,
  parameter int SHORT_IMM_W = 8,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        sizeClass,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] indexReg,
  input  logic [IMM_W-1:0]  immOff,
  input  logic              offIsReg,
  input  logic [1:0]        shiftKind,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic              addOffset,
  input  logic              preIndex,
  input  logic              writeBack,
  input  logic              condPass,
  input  logic [DATA_W-1:0] rdWord,
  output logic              outValid,
  output logic [DATA_W-1:0] effAddr,
  output logic [DATA_W-1:0] wbValue,
  output logic              wbEnable,
  output logic [DATA_W-1:0] loadData
);
  agStrobe_t strobe;

  ls_agen_ctrl u_ctrl (
    .reqValid (reqValid),
    .sizeClass(sizeClass),
    .addOffset(addOffset),
    .preIndex (preIndex),
    .writeBack(writeBack),
    .condPass (condPass),
    .strobe   (strobe)
  );

  ls_agen_dp #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .SHORT_IMM_W(SHORT_IMM_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sizeClass(sizeClass),
    .base     (base),
    .indexReg (indexReg),
    .immOff   (immOff),
    .offIsReg (offIsReg),
    .shiftKind(shiftKind),
    .shiftAmt (shiftAmt),
    .rdWord   (rdWord),
    .outValid (outValid),
    .effAddr  (effAddr),
    .wbValue  (wbValue),
    .wbEnable (wbEnable),
    .loadData (loadData)
  );
endmodule

// File: rtl/ls_agen_chk.sv
module ls_agen_chk
  import ls_agen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W = 12,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        sizeClass,
  input logic [DATA_W-1:0] base,
  input logic [DATA_W-1:0] indexReg,
  input logic [IMM_W-1:0]  immOff,
  input logic              offIsReg,
  input logic [1:0]        shiftKind,
  input logic [AMT_W-1:0]  shiftAmt,
  input logic              addOffset,
  input logic              preIndex,
  input logic              writeBack,
  input logic              condPass,
  input logic [DATA_W-1:0] rdWord,
  input logic              outValid,
  input logic [DATA_W-1:0] effAddr,
  input logic [DATA_W-1:0] wbValue,
  input logic              wbEnable,
  input logic [DATA_W-1:0] loadData
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!outValid && !wbEnable));

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!outValid && !wbEnable));

  p_post_addr_is_base_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !preIndex) |=> (effAddr == $past(base)));

  p_pre_addr_is_new_base_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && preIndex) |=> (effAddr == wbValue));

  p_post_writes_back_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && condPass && !preIndex) |=> wbEnable);

  p_cond_fail_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !condPass) |=> !wbEnable);

  p_sbyte_extends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && sizeClass == SZ_SBYTE) |=>
      ((loadData[DATA_W-1:7] == '0) || (&loadData[DATA_W-1:7])));

  p_ubyte_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && sizeClass == SZ_UBYTE) |=> (loadData[DATA_W-1:8] == '0));
endmodule

bind ls_agen ls_agen_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/tb_ls_agen.sv
module tb_ls_agen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  sizeClass = '0;
  logic [31:0] base = '0, indexReg = '0, rdWord = '0;
  logic [11:0] immOff = '0;
  logic        offIsReg = 1'b0;
  logic [1:0]  shiftKind = '0;
  logic [4:0]  shiftAmt = '0;
  logic        addOffset = 1'b1, preIndex = 1'b1, writeBack = 1'b0, condPass = 1'b1;
  logic        outValid, wbEnable;
  logic [31:0] effAddr, wbValue, loadData;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ls_agen dut (.*);

  typedef struct packed {
    logic [31:0] vBase;
    logic [31:0] vIdx;
    logic [11:0] vImm;
    logic        vIsReg;
    logic [1:0]  vShk;
    logic [4:0]  vSha;
    logic        vAdd;
    logic        vPre;
    logic        vWb;
    logic [2:0]  vSize;
    logic        vCond;
    logic [31:0] vRd;
    logic [31:0] xAddr;
    logic [31:0] xWbv;
    logic        xWbe;
    logic [31:0] xLd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R2 R5 R6: pre-index with writeback, word
    '{32'h200, 32'h0, 12'd12, 1'b0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1, 32'hDEADBEEF,
      32'h20C, 32'h20C, 1'b1, 32'hDEADBEEF},
    // R5 R6: post-index always writes back
    '{32'h200, 32'h0, 12'd12, 1'b0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 32'hDEADBEEF,
      32'h200, 32'h20C, 1'b1, 32'hDEADBEEF},
    // R2: full 12-bit immediate subtracted, pre without writeback
    '{32'h1000, 32'h0, 12'hFFF, 1'b0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 32'h11223344,
      32'h1, 32'h1, 1'b0, 32'h11223344},
    // R3 LSL, R8 ubyte lane 0
    '{32'h100, 32'd3, 12'd0, 1'b1, 2'd0, 5'd2, 1'b1, 1'b1, 1'b0, 3'd1, 1'b1, 32'h11223344,
      32'h10C, 32'h10C, 1'b0, 32'h44},
    // R3 LSR, R8 ubyte lane 1
    '{32'h0, 32'h80000000, 12'd0, 1'b1, 2'd1, 5'd31, 1'b1, 1'b1, 1'b0, 3'd1, 1'b1, 32'hA1B2C3D4,
      32'h1, 32'h1, 1'b0, 32'hC3},
    // R3 ASR of a negative index
    '{32'h1000, 32'hFFFFFFF0, 12'd0, 1'b1, 2'd2, 5'd2, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1, 32'h0,
      32'hFFC, 32'hFFC, 1'b1, 32'h0},
    // R3 ROR, subtracted; R8 lane 1
    '{32'h0, 32'hF0, 12'd0, 1'b1, 2'd3, 5'd4, 1'b0, 1'b1, 1'b0, 3'd1, 1'b1, 32'h00005A00,
      32'hFFFFFFF1, 32'hFFFFFFF1, 1'b0, 32'h5A},
    // R4: uhalf ignores immOff[11:8]; R8 upper half zero-extended
    '{32'h400, 32'h0, 12'hF06, 1'b0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 3'd2, 1'b1, 32'hBEEF1234,
      32'h406, 32'h406, 1'b0, 32'h0000BEEF},
    // R4: shalf ignores index shift; R8 sign-extend from bit 15
    '{32'h500, 32'd2, 12'd0, 1'b1, 2'd0, 5'd4, 1'b1, 1'b1, 1'b0, 3'd4, 1'b1, 32'h80010000,
      32'h502, 32'h502, 1'b0, 32'hFFFF8001},
    // R8: sbyte negative, lane 3
    '{32'h600, 32'h0, 12'd3, 1'b0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 32'h80000000,
      32'h603, 32'h603, 1'b0, 32'hFFFFFF80},
    // R8: sbyte positive, lane 2
    '{32'h600, 32'h0, 12'd2, 1'b0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 32'h007F0000,
      32'h602, 32'h602, 1'b0, 32'h7F},
    // R7: condition failed on post-index
    '{32'h200, 32'h0, 12'd12, 1'b0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 32'h0,
      32'h200, 32'h20C, 1'b0, 32'h0},
    // R5 R6: post-index subtract, shalf lane 0 positive
    '{32'h10, 32'h0, 12'd4, 1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b1, 32'h12347FFE,
      32'h10, 32'hC, 1'b1, 32'h00007FFE},
    // R8: uhalf lane 0
    '{32'h10, 32'h0, 12'd0, 1'b0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 3'd2, 1'b1, 32'h0000F00D,
      32'h10, 32'h10, 1'b0, 32'h0000F00D}
  };

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check32("R1 outValid in reset", {31'b0, outValid}, 32'd0);
    check32("R1 wbEnable in reset", {31'b0, wbEnable}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      reqValid  = 1'b1;
      base      = VECS[i].vBase;
      indexReg  = VECS[i].vIdx;
      immOff    = VECS[i].vImm;
      offIsReg  = VECS[i].vIsReg;
      shiftKind = VECS[i].vShk;
      shiftAmt  = VECS[i].vSha;
      addOffset = VECS[i].vAdd;
      preIndex  = VECS[i].vPre;
      writeBack = VECS[i].vWb;
      sizeClass = VECS[i].vSize;
      condPass  = VECS[i].vCond;
      rdWord    = VECS[i].vRd;
      @(negedge clk);
      check32($sformatf("R9 vec %0d outValid", i), {31'b0, outValid}, 32'd1);
      check32($sformatf("R2 R3 R4 R5 vec %0d effAddr", i), effAddr, VECS[i].xAddr);
      check32($sformatf("R6 vec %0d wbValue", i), wbValue, VECS[i].xWbv);
      check32($sformatf("R6 R7 vec %0d wbEnable", i), {31'b0, wbEnable}, {31'b0, VECS[i].xWbe});
      check32($sformatf("R8 vec %0d loadData", i), loadData, VECS[i].xLd);
    end

    // R9: idle cycle with post-index controls set gives no valid and no writeback
    reqValid = 1'b0; preIndex = 1'b0; condPass = 1'b1;
    @(negedge clk);
    check32("R9 idle outValid", {31'b0, outValid}, 32'd0);
    check32("R6 idle wbEnable", {31'b0, wbEnable}, 32'd0);

    // R1: reset during a writing request clears outputs
    reqValid = 1'b1; base = 32'h40; immOff = 12'd4; sizeClass = 3'd0; addOffset = 1'b1;
    rstN = 1'b0;
    @(negedge clk);
    check32("R1 mid-run reset outValid", {31'b0, outValid}, 32'd0);
    check32("R1 mid-run reset wbEnable", {31'b0, wbEnable}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check32("R5 after reset post addr", effAddr, 32'h40);
    check32("R6 after reset post wb", {31'b0, wbEnable}, 32'd1);
    reqValid = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule